// File: doc/BRIEF.md
# Block-Protected Configuration Byte Store

This block holds 512 bytes of module description data in flip-flops and serves them through a simple synchronous host port. Each cycle the host presents a byte address. It may also assert a write strobe with a data byte. Read data for that address comes back on the next cycle. The byte space is split into four equal 128-byte blocks, and the block index is the top two address bits. Each block has its own write-protect bit, which software can set and clear again at any time.

A write that targets a protected block is discarded, and a sticky reject flag records that it happened. Bytes 256 to 319 form a reserved window that always reads 00h. A write into that window is accepted but has no effect. The intended use is to lock the three lower blocks (bytes 0 to 383) after programming and to leave the top block writable by the user.

A two-state reject tracker drives the sticky flag:
- State CLEAN: no blocked write has been seen since reset.
- State FLAGGED: at least one blocked write has been seen.
- Transition BLOCKED_WRITE takes CLEAN to FLAGGED when a write strobe hits a protected block.
- Transition HOLD keeps FLAGGED until reset.

Top module: `blkprot_store`

## Requirements
- R1: After reset, all four protect bits are 0 and the reject flag is 0. Every byte of the array also reads 00h after reset.
- R2: `rd_data_o` shows the byte at the address presented on the previous cycle, whatever the protect bits hold. If that same cycle also wrote the byte, the read returns the value from before the write.
- R3: A write strobe to a byte in an unprotected block, outside the reserved window, stores `wr_data_i`. A later read returns the stored value.
- R4: The block index is address bits [8:7]: 0 covers 000h–07Fh, 1 covers 080h–0FFh, 2 covers 100h–17Fh and 3 covers 180h–1FFh. Protecting one block leaves the other three writable.
- R5: A cycle with `prot_set_i` high and `prot_clr_i` low sets bit `prot_blk_i` of `prot_o` on the next cycle. The other bits are unchanged.
- R6: A cycle with `prot_clr_i` high clears all four bits of `prot_o` on the next cycle. This holds even if `prot_set_i` is high in the same cycle.
- R7: A write strobe to a byte in a protected block leaves that byte unchanged.
- R8: `wr_rej_o` goes high on the cycle after a write strobe hits a protected block (transition BLOCKED_WRITE). It then stays high until reset (HOLD).
- R9: Bytes 256–319 always read 00h. A write there while block 2 is unprotected changes nothing and does not raise `wr_rej_o`.
- R10: A write in the same cycle as a protect or clear command is judged against the protect bits as they stood before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 9 | Byte address for the read and for any write |
| wr_en_i | input | 1 | Write strobe for the byte at `addr_i` |
| wr_data_i | input | 8 | Data byte for the write |
| rd_data_o | output | 8 | Byte read from the address of the previous cycle |
| prot_set_i | input | 1 | Strobe that sets the protect bit of one block |
| prot_blk_i | input | 2 | Block index for `prot_set_i` |
| prot_clr_i | input | 1 | Strobe that clears every protect bit |
| prot_o | output | 4 | Current protect bits, bit n belongs to block n |
| wr_rej_o | output | 1 | Sticky flag: a write was refused |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. The read byte, the protect bits and the reject flag all follow from the inputs presented in the previous cycle. The bench drives each stimulus just after a falling edge and passes the following rising edge. It then compares all three outputs at the next falling edge against a model that was updated from the same stimulus. In that model, reads see the memory state from before the write and protection sees the protect bits from before the command. This makes the ordering corners of R2 and R10 fall out of the same one-cycle bookkeeping.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

    typedef enum logic {
        RJ_CLEAN   = 1'b0,
        RJ_FLAGGED = 1'b1
    } rej_state_t;

endpackage

// File: rtl/blkprot_flags.sv
module blkprot_flags #(
    parameter int NUM_BLK = 4,
    localparam int BLK_IDX_W = $clog2(NUM_BLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_i,
    input  logic [BLK_IDX_W-1:0] blk_i,
    input  logic                 clr_i,
    output logic [NUM_BLK-1:0]   prot_q
);

    // One flop per block; clear-all takes priority over set.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                prot_q[g] <= 1'b0;
            else if (clr_i)
                prot_q[g] <= 1'b0;
            else if (set_i && (blk_i == BLK_IDX_W'(g)))
                prot_q[g] <= 1'b1;
        end
    end

    // R6: a clear leaves every bit low
    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (prot_q == '0));

    // R5: a set raises its bit and keeps the others
    p_set_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (prot_q[$past(blk_i)] &&
                               ((prot_q | (NUM_BLK'(1) << $past(blk_i))) ==
                                ($past(prot_q) | (NUM_BLK'(1) << $past(blk_i))))));

endmodule

// File: rtl/blkprot_rejfsm.sv
module blkprot_rejfsm
    import blkprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blocked_i,
    output logic rej_o
);

    rej_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RJ_CLEAN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RJ_CLEAN:   if (blocked_i) state_d = RJ_FLAGGED;  // BLOCKED_WRITE
            RJ_FLAGGED: state_d = RJ_FLAGGED;                 // HOLD
        endcase
    end

    always_comb begin
        unique case (state_q)
            RJ_CLEAN:   rej_o = 1'b0;
            RJ_FLAGGED: rej_o = 1'b1;
        endcase
    end

    // R8: once raised, the flag stays up
    p_rej_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |=> rej_o);

    // R8: a blocked write raises the flag on the next cycle
    p_rej_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_i |=> rej_o);

endmodule

// File: rtl/blkprot_array.sv
module blkprot_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              zero_rd_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    // Read sees the contents before any write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else
            rdata_o <= zero_rd_i ? '0 : mem[addr_i];
    end

    // R7: a byte not written this cycle keeps its value
    p_hold_unwritten_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> (mem[$past(addr_i)] == $past(mem[addr_i])));

    // R9: reserved reads come back as zero
    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd_i |=> (rdata_o == '0));

endmodule

// File: rtl/blkprot_store.sv
module blkprot_store #(
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 8,
    parameter int NUM_BLK = 4,
    parameter int RSV_LO  = 256,
    parameter int RSV_HI  = 319,
    localparam int BLK_IDX_W = $clog2(NUM_BLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic                 prot_set_i,
    input  logic [BLK_IDX_W-1:0] prot_blk_i,
    input  logic                 prot_clr_i,
    output logic [NUM_BLK-1:0]   prot_o,
    output logic                 wr_rej_o
);

    localparam logic [ADDR_W-1:0] RSV_LO_A = ADDR_W'(RSV_LO);
    localparam logic [ADDR_W-1:0] RSV_HI_A = ADDR_W'(RSV_HI);

    logic [BLK_IDX_W-1:0] blk_sel;
    logic                 blk_locked;
    logic                 in_rsv;
    logic                 blocked_wr;
    logic                 commit_wr;

    assign blk_sel    = addr_i[ADDR_W-1 -: BLK_IDX_W];
    assign blk_locked = prot_o[blk_sel];
    assign in_rsv     = (addr_i >= RSV_LO_A) && (addr_i <= RSV_HI_A);
    assign blocked_wr = wr_en_i && blk_locked;
    assign commit_wr  = wr_en_i && !blk_locked && !in_rsv;

    blkprot_flags #(.NUM_BLK(NUM_BLK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (prot_set_i),
        .blk_i  (prot_blk_i),
        .clr_i  (prot_clr_i),
        .prot_q (prot_o)
    );

    blkprot_rejfsm u_rej (
        .clk       (clk),
        .rst_n     (rst_n),
        .blocked_i (blocked_wr),
        .rej_o     (wr_rej_o)
    );

    blkprot_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .we_i      (commit_wr),
        .wdata_i   (wr_data_i),
        .zero_rd_i (in_rsv),
        .rdata_o   (rd_data_o)
    );

    // R8: the flag only rises after a write to a protected block
    p_rej_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_rej_o) |-> $past(wr_en_i && prot_o[addr_i[ADDR_W-1 -: BLK_IDX_W]]));

    // R9: an unprotected reserved write never flags a reject
    p_rsv_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && in_rsv && !blk_locked && !wr_rej_o) |=> !wr_rej_o);

endmodule

// File: tb/sim_blkprot_store.sv
module sim_blkprot_store;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic       ps = 1'b0;
    logic [1:0] pb = '0;
    logic       pc = 1'b0;
    logic [3:0] prot;
    logic       rej;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_mem [512];
    logic [3:0] m_prot;
    logic       m_rej;
    logic [7:0] m_rd;

    always #2.5 clk = ~clk;

    blkprot_store u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
        .rd_data_o(rd), .prot_set_i(ps), .prot_blk_i(pb), .prot_clr_i(pc),
        .prot_o(prot), .wr_rej_o(rej)
    );

    function automatic bit is_rsv(logic [8:0] a);
        return (a >= 9'd256) && (a <= 9'd319);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
        m_prot = '0;
        m_rej  = 1'b0;
        m_rd   = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; ps = 1'b0; pc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One cycle: drive at a falling edge, update the model, check at the next falling edge.
    task automatic step(logic [8:0] a, logic w, logic [7:0] d,
                        logic s, logic [1:0] b, logic c, string tag);
        logic locked;
        addr = a; we = w; wd = d; ps = s; pb = b; pc = c;
        m_rd   = is_rsv(a) ? 8'h00 : m_mem[a];
        locked = m_prot[a[8:7]];
        if (w && locked) m_rej = 1'b1;
        else if (w && !is_rsv(a)) m_mem[a] = d;
        if (c) m_prot = '0;
        else if (s) m_prot[b] = 1'b1;
        @(negedge clk);
        chk({tag, "/R2 rd"}, rd, m_rd);
        chk({tag, "/R5 prot"}, prot, m_prot);
        chk({tag, "/R8 rej"}, rej, m_rej);
        we = 1'b0; ps = 1'b0; pc = 1'b0;
    endtask

    task automatic rd_at(logic [8:0] a, string tag);
        step(a, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] edges [9];
        edges = '{9'd0, 9'd127, 9'd128, 9'd255, 9'd256, 9'd319, 9'd320, 9'd383, 9'd511};
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 prot", prot, 0);
        chk("R1 rej", rej, 0);
        rd_at(9'h005, "R1");
        rd_at(9'h1FF, "R1");

        // R3: plain write then read back
        step(9'h1A5, 1'b1, 8'h5C, 1'b0, 2'd0, 1'b0, "R3");
        rd_at(9'h1A5, "R3");
        chk("R3 data", rd, 8'h5C);

        // R2: same-cycle write returns old byte
        step(9'h1A5, 1'b1, 8'h77, 1'b0, 2'd0, 1'b0, "R2");
        chk("R2 old", rd, 8'h5C);

        // R5 / R4: protect block 1 only
        step(9'h080, 1'b1, 8'h11, 1'b1, 2'd1, 1'b0, "R5");
        chk("R5 bit1", prot, 4'b0010);
        step(9'h0FF, 1'b1, 8'h22, 1'b0, 2'd0, 1'b0, "R7");
        chk("R8 set", rej, 1);
        rd_at(9'h0FF, "R7");
        chk("R7 unchanged", rd, 8'h00);
        rd_at(9'h080, "R10");
        chk("R10 pre-set write kept", rd, 8'h11);
        step(9'h07F, 1'b1, 8'h33, 1'b0, 2'd0, 1'b0, "R4");
        rd_at(9'h07F, "R4");
        chk("R4 blk0 writable", rd, 8'h33);
        rd_at(9'h0C0, "R2");
        chk("R8 hold", rej, 1);

        // R6: clear wins over set
        step(9'h000, 1'b0, 8'h00, 1'b1, 2'd3, 1'b1, "R6");
        chk("R6 clear", prot, 4'b0000);

        // R9: reserved window
        do_reset();
        step(9'h100, 1'b1, 8'hAB, 1'b0, 2'd0, 1'b0, "R9");
        rd_at(9'h100, "R9");
        chk("R9 zero", rd, 8'h00);
        chk("R9 noflag", rej, 0);
        step(9'h140, 1'b1, 8'hCD, 1'b0, 2'd0, 1'b0, "R9");
        rd_at(9'h140, "R9");
        chk("R9 above window", rd, 8'hCD);

        // R10: protect of block 3 and write in the same cycle
        step(9'h1F0, 1'b1, 8'h99, 1'b1, 2'd3, 1'b0, "R10");
        rd_at(9'h1F0, "R10");
        chk("R10 write", rd, 8'h99);
        chk("R10 noflag", rej, 0);
        // R10: clear and write to protected block in the same cycle is refused
        step(9'h1F0, 1'b1, 8'h01, 1'b0, 2'd0, 1'b1, "R10");
        chk("R10 rej", rej, 1);
        rd_at(9'h1F0, "R10");
        chk("R10 kept", rd, 8'h99);

        // Random mix
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [8:0] a;
            int r;
            r = $urandom_range(0, 99);
            a = (r < 20) ? edges[$urandom_range(0, 8)] : 9'($urandom_range(0, 511));
            step(a, ($urandom_range(0, 1) == 1), 8'($urandom),
                 ($urandom_range(0, 99) < 6), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 99) < 3), "RND");
            if (k % 1000 == 999) do_reset();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule